// File: doc/BRIEF.md
# Byte-Wide Static Memory with Single-Error Correction

This block models a byte-wide static memory in which every stored byte carries four Hamming check bits. The model is synchronous to a single clock. A caller selects the memory through two chip selects of opposite polarity. At a clock edge it then either writes a byte with an active-low write strobe or requests a read with an active-low output enable. A read returns the corrected byte one cycle later. It also raises an error flag when a single flipped bit was found and repaired on the way out.

The data bus is split into an input, an output and an output-drive enable. The error flag has its own drive enable. Both enables are low whenever the pins would float: when the device is deselected, when the output enable is inactive, or while a write is in progress. Correction is applied only to the returned byte and is never written back. A damaged location is therefore flagged on every read until it is rewritten. A test port XORs a one-hot mask into any stored 12-bit codeword, so that faults can be placed at every bit position.

Top module: `bytesram_sec`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `dq_oe` and `err_oe` are 0, and `dq_out` and `err_out` are 0.
- R2: At a clock edge where `cs_a_n`=0, `cs_b`=1 and `we_n`=0, the byte on `dq_in` is stored at `addr`, whatever the level of `oe_n`.
- R3: At an edge where `cs_a_n`=0, `cs_b`=1, `we_n`=1 and `oe_n`=0, the cycle that follows has `dq_oe`=1 and `err_oe`=1, with `dq_out` equal to the byte stored at `addr`. For a clean word `err_out` is 0.
- R4: When `cs_a_n`=1 or `cs_b`=0 at an edge, nothing is stored, and in the next cycle `dq_oe` and `err_oe` are 0, regardless of `we_n` and `oe_n`.
- R5: After an edge with `oe_n`=1, or after a write edge, `dq_oe` and `err_oe` are 0. Whenever `dq_oe` is 0, `dq_out` and `err_out` read 0.
- R6: The codeword has 12 bits. Mask bit i is codeword position i+1. Check bits sit at positions 1, 2, 4 and 8, and data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12. When any single position is flipped, a read returns the original byte with `err_out`=1.
- R7: A corrected read leaves the stored word unchanged, so repeated reads flag the same error again. Rewriting the location clears the error.
- R8: At an edge with `inj_en`=1, the word at `inj_addr` is XORed with `inj_mask`, which must be one-hot. Applying the same mask twice restores the word. An injection takes priority over a write in the same cycle, and that write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Byte address, AW = clog2(DEPTH) |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_in | input | 8 | Write data |
| dq_out | output | 8 | Corrected read data |
| dq_oe | output | 1 | Data bus drive enable |
| err_out | output | 1 | Single-error-corrected flag |
| err_oe | output | 1 | Flag drive enable |
| inj_en | input | 1 | Fault injection strobe |
| inj_addr | input | AW | Fault injection address |
| inj_mask | input | 12 | One-hot codeword flip mask |

## Verification
The bench builds the memory with DEPTH=64. With that depth, both address 0 and the last address, 63, appear in the stimulus table, and the address width shrinks to six bits. The codeword width is fixed at 12 bits. Because of that, a short loop can sweep a fault through every check and data position and then remove it again by re-injecting the same mask.

// File: rtl/bsram_ecc_pkg.sv
package bsram_ecc_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int CODE_W = DATA_W + CHK_W;

  function automatic bit is_chk_pos(int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  // Codeword position (1-based) holding data bit j.
  function automatic int data_pos(int j);
    int pos;
    int n;
    pos = 0;
    n   = -1;
    while (n < j) begin
      pos++;
      if (!is_chk_pos(pos)) n++;
    end
    return pos;
  endfunction

  // Positions whose index has bit k set.
  function automatic logic [CODE_W-1:0] cov_mask(int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int pos = 1; pos <= CODE_W; pos++)
      if (((pos >> k) & 1) == 1) m = m | (CODE_W'(1) << (pos - 1));
    return m;
  endfunction
endpackage

// File: rtl/bsram_ecc_enc.sv
module bsram_ecc_enc
  import bsram_ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] placed;
  logic [CHK_W-1:0]  chk;

  for (genvar j = 0; j < DATA_W; j++) begin : g_place
    assign placed[data_pos(j)-1] = data_i[j];
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    assign placed[(1 << k)-1] = 1'b0;
    assign chk[k] = ^(placed & cov_mask(k));
  end

  for (genvar p = 1; p <= CODE_W; p++) begin : g_out
    if ((p & (p - 1)) == 0) begin : g_c
      assign code_o[p-1] = chk[$clog2(p)];
    end else begin : g_d
      assign code_o[p-1] = placed[p-1];
    end
  end
endmodule

// File: rtl/bsram_ecc_dec.sv
module bsram_ecc_dec
  import bsram_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_fix_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fixed_o
);
  logic [CHK_W-1:0]  syn;
  logic [CODE_W-1:0] flip;

  for (genvar k = 0; k < CHK_W; k++) begin : g_syn
    assign syn[k] = ^(code_i & cov_mask(k));
  end

  for (genvar p = 1; p <= CODE_W; p++) begin : g_flip
    assign flip[p-1] = (syn == CHK_W'(p));
  end

  assign code_fix_o = code_i ^ flip;
  assign fixed_o    = |flip;

  for (genvar j = 0; j < DATA_W; j++) begin : g_ext
    assign data_o[j] = code_fix_o[data_pos(j)-1];
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int W     = 12
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic          inj_en,
  input  logic [AW-1:0] inj_addr,
  input  logic [W-1:0]  inj_mask,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (inj_en)
      mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    else if (wr_en)
      mem[wr_addr] <= wr_word;
    rd_word <= mem[rd_addr];
  end
endmodule

// File: rtl/bytesram_sec.sv
module bytesram_sec
  import bsram_ecc_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              err_out,
  output logic              err_oe,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [CODE_W-1:0] inj_mask
);
  logic              sel, wr_cmd, rd_cmd, rd_q;
  logic [CODE_W-1:0] wr_code, raw_code, fix_code;
  logic [DATA_W-1:0] dec_data;
  logic              dec_fixed;

  assign sel    = ~cs_a_n & cs_b;
  assign wr_cmd = sel & ~we_n;
  assign rd_cmd = sel & we_n & ~oe_n;

  bsram_ecc_enc u_enc (.data_i(dq_in), .code_o(wr_code));

  bsram_array #(.DEPTH(DEPTH), .AW(AW), .W(CODE_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_cmd),
    .wr_addr (addr),
    .wr_word (wr_code),
    .inj_en  (inj_en),
    .inj_addr(inj_addr),
    .inj_mask(inj_mask),
    .rd_addr (addr),
    .rd_word (raw_code)
  );

  bsram_ecc_dec u_dec (
    .code_i    (raw_code),
    .code_fix_o(fix_code),
    .data_o    (dec_data),
    .fixed_o   (dec_fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_cmd;
  end

  assign dq_oe   = rd_q;
  assign err_oe  = rd_q;
  assign dq_out  = rd_q ? dec_data : '0;
  assign err_out = rd_q & dec_fixed;

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !dq_oe && !err_oe);
  // R3
  p_read_drive_r3: assert property (@(posedge clk) disable iff (rst)
    (!cs_a_n && cs_b && we_n && !oe_n) |=> dq_oe && err_oe);
  // R4
  p_desel_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (cs_a_n || !cs_b) |=> !dq_oe && !err_oe);
  // R5
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_a_n && cs_b && !we_n) |=> !dq_oe && !err_oe);
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> dq_out == '0 && !err_out);
  // R6
  p_fix_onebit_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $countones(raw_code ^ fix_code) <= 1);
  // R8
  p_inj_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    inj_en |-> $countones(inj_mask) == 1);
endmodule

// File: tb/bytesram_sec_bench.sv
module bytesram_sec_bench;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int NV    = 8;
  localparam logic [AW+7:0] VEC [NV] = '{
    {6'd0,  8'h3C}, {6'd63, 8'hFF}, {6'd1,  8'h00}, {6'd5,  8'h11},
    {6'd32, 8'h80}, {6'd17, 8'h01}, {6'd42, 8'h96}, {6'd31, 8'h7E}
  };

  logic clk = 0, rst = 1;
  logic [AW-1:0] addr = '0, inj_addr = '0;
  logic cs_a_n = 1, cs_b = 0, we_n = 1, oe_n = 1, inj_en = 0;
  logic [7:0] dq_in = '0, dq_out;
  logic [11:0] inj_mask = 12'h001;
  logic dq_oe, err_out, err_oe;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bytesram_sec #(.DEPTH(DEPTH)) u_bytesram_sec (
    .clk(clk), .rst(rst), .addr(addr), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .we_n(we_n), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .err_out(err_out), .err_oe(err_oe), .inj_en(inj_en), .inj_addr(inj_addr),
    .inj_mask(inj_mask)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cs_a_n = 1; cs_b = 0; we_n = 1; oe_n = 1; inj_en = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d, logic oe_lvl);
    cs_a_n = 0; cs_b = 1; we_n = 0; oe_n = oe_lvl; addr = a; dq_in = d;
    step();
    idle();
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d, output logic f,
                    output logic oe);
    cs_a_n = 0; cs_b = 1; we_n = 1; oe_n = 0; addr = a;
    step();
    d = dq_out; f = err_out; oe = dq_oe & err_oe;
    idle();
  endtask

  task automatic inject(logic [AW-1:0] a, logic [11:0] m);
    inj_en = 1; inj_addr = a; inj_mask = m;
    step();
    inj_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic f, oe;
    @(negedge clk);
    step();
    // R1: reset state
    check("R1 oe", {30'd0, dq_oe, err_oe}, 0);
    check("R1 out", {23'd0, dq_out, err_out}, 0);
    rst = 0;
    step();
    check("R1 after", {30'd0, dq_oe, err_oe}, 0);

    // R2/R3 table walk
    for (int i = 0; i < NV; i++) wr(VEC[i][AW+7:8], VEC[i][7:0], i[0]);
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][AW+7:8], d, f, oe);
      check("R2 R3 data", {24'd0, d}, {24'd0, VEC[i][7:0]});
      check("R3 flag", {31'd0, f}, 0);
      check("R3 drive", {31'd0, oe}, 1);
    end

    // R4: deselected writes dropped, deselected read quiet
    cs_a_n = 1; cs_b = 1; we_n = 0; addr = 6'd5; dq_in = 8'hEE; step(); idle();
    cs_a_n = 0; cs_b = 0; we_n = 0; addr = 6'd5; dq_in = 8'hDD; step(); idle();
    rd(6'd5, d, f, oe);
    check("R4 no store", {24'd0, d}, 32'h11);
    cs_a_n = 1; cs_b = 1; we_n = 1; oe_n = 0; addr = 6'd5; step();
    check("R4 quiet", {30'd0, dq_oe, err_oe}, 0);
    idle();

    // R5: output disabled, write cycle quiet
    cs_a_n = 0; cs_b = 1; we_n = 1; oe_n = 1; addr = 6'd5; step();
    check("R5 oe_n high", {30'd0, dq_oe, err_oe}, 0);
    check("R5 zero out", {23'd0, dq_out, err_out}, 0);
    cs_a_n = 0; cs_b = 1; we_n = 0; oe_n = 0; addr = 6'd7; dq_in = 8'h4B; step();
    check("R5 write quiet", {30'd0, dq_oe, err_oe}, 0);
    idle();
    rd(6'd7, d, f, oe);
    check("R2 oe ignored", {24'd0, d}, 32'h4B);

    // R6/R8: sweep a fault through all 12 positions
    wr(6'd10, 8'hA5, 1'b1);
    for (int p = 1; p <= 12; p++) begin
      inject(6'd10, 12'(1) << (p - 1));
      rd(6'd10, d, f, oe);
      check("R6 corrected data", {24'd0, d}, 32'hA5);
      check("R6 flag", {30'd0, f, oe}, 32'h3);
      inject(6'd10, 12'(1) << (p - 1));
      rd(6'd10, d, f, oe);
      check("R8 restore", {23'd0, d, f}, {23'd0, 8'hA5, 1'b0});
    end

    // R7: no write-back
    inject(6'd10, 12'h020);
    rd(6'd10, d, f, oe);
    check("R7 first", {23'd0, d, f}, {23'd0, 8'hA5, 1'b1});
    rd(6'd10, d, f, oe);
    check("R7 again", {23'd0, d, f}, {23'd0, 8'hA5, 1'b1});
    wr(6'd10, 8'h5A, 1'b1);
    rd(6'd10, d, f, oe);
    check("R7 rewrite", {23'd0, d, f}, {23'd0, 8'h5A, 1'b0});

    // R8: injection beats same-cycle write
    wr(6'd20, 8'h33, 1'b1);
    cs_a_n = 0; cs_b = 1; we_n = 0; addr = 6'd20; dq_in = 8'hCC;
    inj_en = 1; inj_addr = 6'd20; inj_mask = 12'h004;
    step();
    idle();
    rd(6'd20, d, f, oe);
    check("R8 priority", {23'd0, d, f}, {23'd0, 8'h33, 1'b1});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule